// File: doc/BRIEF.md
# Banked Clock Register and RAM Port

This block is the host-facing access path of a real-time clock. Software reaches two 128-byte banks, a standard bank and an extended bank, through a pair of index/data ports for each bank. It writes a 7-bit offset to a bank's index port, then reads or writes that bank's data port. In the standard bank, the first ten offsets are a window onto the time and date bytes held by the timekeeping core. The next four offsets are control and status registers A to D, which are built from flops. Every other location in both banks is plain byte storage.

The block steers each access to the right target. It blocks host writes to the time bytes while the core runs an update. When the clock function is switched off, it gates the whole standard data port. The extended bank keeps working in every mode. The timekeeping arithmetic, alarms and battery supply sit outside this block.

Top module: `rtc_bank_port`

## Requirements
- R1: After reset both index registers are 0, `cfg_a`, `cfg_b` and `cfg_d` are 0, and `io_rdata` is 00h.
- R2: `io_addr` selects the port: 0 = standard index, 1 = standard data, 2 = extended index, 3 = extended data. A write to an index port loads `io_wdata[6:0]`. A read of an index port returns `{1'b0, index}`. The data for a read appears on `io_rdata` in the cycle after `io_rd` is sampled and holds until the next read.
- R3: Every extended-bank offset 00h..7Fh stores a byte that is read back unchanged. Extended and standard storage do not affect each other.
- R4: Standard offsets 0Eh..7Fh (114 bytes) store bytes that are read back unchanged.
- R5: A read of standard offset N in 00h..09h returns `tk_time[8N+7:8N]` as sampled with the read. A write there drives `tk_wr_en` high in the same cycle, with `tk_wr_sel` = N and `tk_wr_data` = `io_wdata`.
- R6: While `tk_busy` is 1, a write to standard offsets 00h..09h is dropped and `tk_wr_en` stays 0.
- R7: Offset 0Ah (register A): bits 6:0 are read/write and drive `cfg_a`. Bit 7 reads `tk_busy` and ignores writes.
- R8: Offset 0Bh (register B): all 8 bits are read/write and drive `cfg_b`.
- R9: Offset 0Ch (register C) reads `{tk_flags, 4'b0000}`. Writes to it change nothing.
- R10: Offset 0Dh (register D): bits 6:0 are read/write and drive `cfg_d`. Bit 7 reads `tk_valid` and ignores writes.
- R11: While `clk_en` is 0, standard data reads return FFh. Standard data writes are discarded: no `tk_wr_en`, and no change to registers or storage.
- R12: While `clk_en` is 0, both extended ports and the standard index port work as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 2 | Port select (standard index/data, extended index/data) |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid one cycle after the read |
| clk_en | input | 1 | Clock function enable from configuration |
| tk_time | input | 80 | Ten time/date bytes from the core, byte N at bits 8N+7:8N |
| tk_busy | input | 1 | Core update cycle in progress |
| tk_flags | input | 4 | Core event flags shown in register C |
| tk_valid | input | 1 | Core time-valid status shown in register D |
| tk_wr_en | output | 1 | Host write strobe to a time byte |
| tk_wr_sel | output | 4 | Time byte selected by the write |
| tk_wr_data | output | 8 | Data for the time byte |
| cfg_a | output | 7 | Writable bits of register A |
| cfg_b | output | 8 | Register B |
| cfg_d | output | 7 | Writable bits of register D |

## Verification
The assertions take it for granted that the host never raises `io_rd` and `io_wr` in the same cycle. They also assume that `clk_en` and `tk_busy` change only between host cycles. The result of a read is then decided by the state at the sampling edge. The bench drives every input at the falling edge, issues exactly one strobe per operation, and draws `clk_en`, `tk_busy`, the flags and the time bytes at random only between operations. Before any random read, both banks are filled with known bytes so that no location reads back undefined.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

  typedef enum logic [1:0] {
    PORT_STD_IDX = 2'd0,
    PORT_STD_DAT = 2'd1,
    PORT_EXT_IDX = 2'd2,
    PORT_EXT_DAT = 2'd3
  } port_sel_e;

  // where the held read value comes from
  typedef enum logic [1:0] {
    RSRC_IMM = 2'd0,
    RSRC_STD = 2'd1,
    RSRC_EXT = 2'd2
  } rd_src_e;

  // which flop-based value is captured for an immediate read
  typedef enum logic [2:0] {
    IMM_STD_IDX = 3'd0,
    IMM_EXT_IDX = 3'd1,
    IMM_ONES    = 3'd2,
    IMM_TIME    = 3'd3,
    IMM_CTRL    = 3'd4
  } imm_sel_e;

endpackage

// File: rtl/rtc_bank_ram.sv
module rtc_bank_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q;

  // storage array: no reset, single port, synchronous read
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
    if (rd_en) begin
      q <= mem[addr];
    end
  end

  assign rdata = q;

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tk_busy,
  input  logic [FLAG_W-1:0] tk_flags,
  input  logic              tk_valid,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-2:0] cfg_a,
  output logic [DATA_W-1:0] cfg_b,
  output logic [DATA_W-2:0] cfg_d
);
  localparam logic [SEL_W-1:0] SEL_A = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_B = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_C = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_D = SEL_W'(3);

  logic [DATA_W-2:0] a_q, a_d;
  logic [DATA_W-1:0] b_q, b_d;
  logic [DATA_W-2:0] d_q, d_d;
  logic              a_en, b_en, d_en;

  // next state; register C has no storage, so a write there is lost
  always_comb begin
    a_en = wr_en && (wr_sel == SEL_A);
    b_en = wr_en && (wr_sel == SEL_B);
    d_en = wr_en && (wr_sel == SEL_D);
    a_d  = wdata[DATA_W-2:0];
    b_d  = wdata;
    d_d  = wdata[DATA_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      d_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
      if (d_en) d_q <= d_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_A:   rd_val = {tk_busy, a_q};
      SEL_B:   rd_val = b_q;
      SEL_C:   rd_val = {tk_flags, {(DATA_W-FLAG_W){1'b0}}};
      default: rd_val = {tk_valid, d_q};
    endcase
  end

  assign cfg_a = a_q;
  assign cfg_b = b_q;
  assign cfg_d = d_q;

endmodule

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
  import rtc_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int TIME_N = 10,
  parameter int CTRL_N = 4,
  parameter int CSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              clk_en,
  input  logic              tk_busy,
  output logic [ADDR_W-1:0] std_idx,
  output logic [ADDR_W-1:0] ext_idx,
  output logic              std_ram_we,
  output logic              std_ram_re,
  output logic              ext_ram_we,
  output logic              ext_ram_re,
  output logic              time_we,
  output logic              ctrl_we,
  output logic [CSEL_W-1:0] ctrl_sel,
  output logic              rd_load,
  output rd_src_e           rd_src_nxt,
  output imm_sel_e          imm_sel_nxt
);
  localparam int GP_BASE = TIME_N + CTRL_N;
  localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(TIME_N);
  localparam logic [ADDR_W-1:0] GP_START = ADDR_W'(GP_BASE);

  logic [ADDR_W-1:0] std_idx_q, ext_idx_q;
  logic              std_idx_en, ext_idx_en;
  logic              sel_std_dat, sel_ext_dat;
  logic              in_time, in_ctrl, in_gp;

  always_comb begin
    std_idx_en  = io_wr && (io_addr == PORT_STD_IDX);
    ext_idx_en  = io_wr && (io_addr == PORT_EXT_IDX);
    sel_std_dat = (io_addr == PORT_STD_DAT);
    sel_ext_dat = (io_addr == PORT_EXT_DAT);
    in_time     = (std_idx_q < TIME_END);
    in_ctrl     = !in_time && (std_idx_q < GP_START);
    in_gp       = !in_time && !in_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_idx_q <= '0;
      ext_idx_q <= '0;
    end else begin
      if (std_idx_en) std_idx_q <= io_wdata[ADDR_W-1:0];
      if (ext_idx_en) ext_idx_q <= io_wdata[ADDR_W-1:0];
    end
  end

  // write steering: standard data is gated by the enable, time bytes by the update
  always_comb begin
    std_ram_we = io_wr && sel_std_dat && clk_en && in_gp;
    std_ram_re = io_rd && sel_std_dat && clk_en && in_gp;
    ext_ram_we = io_wr && sel_ext_dat;
    ext_ram_re = io_rd && sel_ext_dat;
    time_we    = io_wr && sel_std_dat && clk_en && in_time && !tk_busy;
    ctrl_we    = io_wr && sel_std_dat && clk_en && in_ctrl;
    ctrl_sel   = CSEL_W'(std_idx_q - TIME_END);
  end

  // read steering
  always_comb begin
    rd_load     = io_rd;
    rd_src_nxt  = RSRC_IMM;
    imm_sel_nxt = IMM_STD_IDX;
    unique case (io_addr)
      PORT_STD_IDX: imm_sel_nxt = IMM_STD_IDX;
      PORT_EXT_IDX: imm_sel_nxt = IMM_EXT_IDX;
      PORT_EXT_DAT: rd_src_nxt  = RSRC_EXT;
      default: begin
        if (!clk_en)      imm_sel_nxt = IMM_ONES;
        else if (in_time) imm_sel_nxt = IMM_TIME;
        else if (in_ctrl) imm_sel_nxt = IMM_CTRL;
        else              rd_src_nxt  = RSRC_STD;
      end
    endcase
  end

  assign std_idx = std_idx_q;
  assign ext_idx = ext_idx_q;

endmodule

// File: rtl/rtc_bank_port.sv
module rtc_bank_port
  import rtc_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int TIME_N = 10,
  parameter int CTRL_N = 4,
  parameter int FLAG_W = 4,
  parameter int TSEL_W = $clog2(TIME_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [DATA_W-1:0]        io_wdata,
  output logic [DATA_W-1:0]        io_rdata,
  input  logic                     clk_en,
  input  logic [TIME_N*DATA_W-1:0] tk_time,
  input  logic                     tk_busy,
  input  logic [FLAG_W-1:0]        tk_flags,
  input  logic                     tk_valid,
  output logic                     tk_wr_en,
  output logic [TSEL_W-1:0]        tk_wr_sel,
  output logic [DATA_W-1:0]        tk_wr_data,
  output logic [DATA_W-2:0]        cfg_a,
  output logic [DATA_W-1:0]        cfg_b,
  output logic [DATA_W-2:0]        cfg_d
);
  localparam int CSEL_W = $clog2(CTRL_N);

  logic [ADDR_W-1:0] std_idx, ext_idx;
  logic              std_ram_we, std_ram_re, ext_ram_we, ext_ram_re;
  logic              time_we, ctrl_we, rd_load;
  logic [CSEL_W-1:0] ctrl_sel;
  rd_src_e           rd_src_nxt, rd_src_q;
  imm_sel_e          imm_sel_nxt;
  logic [DATA_W-1:0] std_q, ext_q, ctrl_val, time_byte;
  logic [DATA_W-1:0] imm_d, imm_q;
  logic [DATA_W-1:0] time_bytes [TIME_N];

  generate
    for (genvar gi = 0; gi < TIME_N; gi++) begin : g_time_split
      assign time_bytes[gi] = tk_time[gi*DATA_W +: DATA_W];
    end
  endgenerate

  rtc_port_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_N(TIME_N),
    .CTRL_N(CTRL_N), .CSEL_W(CSEL_W)
  ) decode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .clk_en     (clk_en),
    .tk_busy    (tk_busy),
    .std_idx    (std_idx),
    .ext_idx    (ext_idx),
    .std_ram_we (std_ram_we),
    .std_ram_re (std_ram_re),
    .ext_ram_we (ext_ram_we),
    .ext_ram_re (ext_ram_re),
    .time_we    (time_we),
    .ctrl_we    (ctrl_we),
    .ctrl_sel   (ctrl_sel),
    .rd_load    (rd_load),
    .rd_src_nxt (rd_src_nxt),
    .imm_sel_nxt(imm_sel_nxt)
  );

  rtc_ctrl_regs #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .SEL_W(CSEL_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctrl_we),
    .wr_sel  (ctrl_sel),
    .rd_sel  (ctrl_sel),
    .wdata   (io_wdata),
    .tk_busy (tk_busy),
    .tk_flags(tk_flags),
    .tk_valid(tk_valid),
    .rd_val  (ctrl_val),
    .cfg_a   (cfg_a),
    .cfg_b   (cfg_b),
    .cfg_d   (cfg_d)
  );

  rtc_bank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) std_ram_i (
    .clk  (clk),
    .wr_en(std_ram_we),
    .rd_en(std_ram_re),
    .addr (std_idx),
    .wdata(io_wdata),
    .rdata(std_q)
  );

  rtc_bank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ext_ram_i (
    .clk  (clk),
    .wr_en(ext_ram_we),
    .rd_en(ext_ram_re),
    .addr (ext_idx),
    .wdata(io_wdata),
    .rdata(ext_q)
  );

  // time byte pick; only offsets below TIME_N ever reach this path
  always_comb begin
    time_byte = '0;
    for (int i = 0; i < TIME_N; i++) begin
      if (std_idx == ADDR_W'(i)) time_byte = time_bytes[i];
    end
  end

  always_comb begin
    unique case (imm_sel_nxt)
      IMM_STD_IDX: imm_d = DATA_W'(std_idx);
      IMM_EXT_IDX: imm_d = DATA_W'(ext_idx);
      IMM_ONES:    imm_d = '1;
      IMM_TIME:    imm_d = time_byte;
      default:     imm_d = ctrl_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_src_q <= RSRC_IMM;
      imm_q    <= '0;
    end else if (rd_load) begin
      rd_src_q <= rd_src_nxt;
      imm_q    <= imm_d;
    end
  end

  always_comb begin
    unique case (rd_src_q)
      RSRC_STD: io_rdata = std_q;
      RSRC_EXT: io_rdata = ext_q;
      default:  io_rdata = imm_q;
    endcase
  end

  assign tk_wr_en   = time_we;
  assign tk_wr_sel  = std_idx[TSEL_W-1:0];
  assign tk_wr_data = io_wdata;

endmodule

// File: rtl/rtc_bank_port_chk.sv
module rtc_bank_port_chk #(
  parameter int DATA_W = 8,
  parameter int TIME_N = 10,
  parameter int TSEL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              clk_en,
  input logic              tk_busy,
  input logic              tk_wr_en,
  input logic [TSEL_W-1:0] tk_wr_sel,
  input logic [DATA_W-1:0] tk_wr_data,
  input logic [DATA_W-2:0] cfg_a,
  input logic [DATA_W-1:0] cfg_b,
  input logic [DATA_W-2:0] cfg_d
);
  logic std_dat_wr;
  assign std_dat_wr = io_wr && (io_addr == 2'd1) && clk_en;

  p_wr_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tk_wr_en |-> (io_wr && io_addr == 2'd1 && tk_wr_sel < TSEL_W'(TIME_N)
                  && tk_wr_data == io_wdata));

  p_wr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tk_wr_en |-> !tk_busy);

  p_wr_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tk_wr_en |-> clk_en);

  p_off_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 2'd1 && !clk_en) |=> (io_rdata == '1));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  p_cfg_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !std_dat_wr |=> $stable(cfg_a));

  p_cfg_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !std_dat_wr |=> $stable(cfg_b));

  p_cfg_d_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !std_dat_wr |=> $stable(cfg_d));

endmodule

bind rtc_bank_port rtc_bank_port_chk #(
  .DATA_W(DATA_W), .TIME_N(TIME_N), .TSEL_W(TSEL_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .clk_en    (clk_en),
  .tk_busy   (tk_busy),
  .tk_wr_en  (tk_wr_en),
  .tk_wr_sel (tk_wr_sel),
  .tk_wr_data(tk_wr_data),
  .cfg_a     (cfg_a),
  .cfg_b     (cfg_b),
  .cfg_d     (cfg_d)
);

// File: tb/rtc_bank_port_tb.sv
module rtc_bank_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic        clk_en;
  logic [79:0] tk_time;
  logic        tk_busy;
  logic [3:0]  tk_flags;
  logic        tk_valid;
  logic        tk_wr_en;
  logic [3:0]  tk_wr_sel;
  logic [7:0]  tk_wr_data;
  logic [6:0]  cfg_a;
  logic [7:0]  cfg_b;
  logic [6:0]  cfg_d;

  int checks;
  int failures;

  logic [7:0] std_m [128];
  logic [7:0] ext_m [128];
  logic [6:0] a_m, d_m;
  logic [7:0] b_m;
  logic [6:0] sidx_m, eidx_m;

  logic       seen_we;
  logic [3:0] seen_sel;
  logic [7:0] seen_dat;

  rtc_bank_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .clk_en(clk_en), .tk_time(tk_time),
    .tk_busy(tk_busy), .tk_flags(tk_flags), .tk_valid(tk_valid),
    .tk_wr_en(tk_wr_en), .tk_wr_sel(tk_wr_sel), .tk_wr_data(tk_wr_data),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_d(cfg_d)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1;
    seen_we = tk_wr_en; seen_sel = tk_wr_sel; seen_dat = tk_wr_data;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 2'd0) sidx_m = d[6:0];
    if (a == 2'd2) eidx_m = d[6:0];
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  // expected standard data read for the current inputs
  function automatic logic [7:0] exp_std(input logic [6:0] off);
    if (!clk_en)        return 8'hFF;
    if (off < 7'd10)    return tk_time[off*8 +: 8];
    if (off == 7'd10)   return {tk_busy, a_m};
    if (off == 7'd11)   return b_m;
    if (off == 7'd12)   return {tk_flags, 4'b0};
    if (off == 7'd13)   return {tk_valid, d_m};
    return std_m[off];
  endfunction

  function automatic string std_tag(input logic [6:0] off);
    if (!clk_en)      return "R11";
    if (off < 7'd10)  return "R5";
    if (off == 7'd10) return "R7";
    if (off == 7'd11) return "R8";
    if (off == 7'd12) return "R9";
    if (off == 7'd13) return "R10";
    return "R4";
  endfunction

  // standard data write with model update and strobe check
  task automatic std_write(input logic [7:0] d);
    logic exp_we;
    logic [6:0] off;
    off = sidx_m;
    exp_we = clk_en && off < 7'd10 && !tk_busy;
    wr(2'd1, d);
    check(clk_en ? ((off < 7'd10) ? "R6" : "R5") : "R11", {31'd0, seen_we}, {31'd0, exp_we});
    if (exp_we) check("R5", {20'd0, seen_sel, seen_dat}, {20'd0, off[3:0], d});
    if (clk_en) begin
      if (off == 7'd10) a_m = d[6:0];
      if (off == 7'd11) b_m = d;
      if (off == 7'd13) d_m = d[6:0];
      if (off >= 7'd14) std_m[off] = d;
    end
    check("R7", {25'd0, cfg_a}, {25'd0, a_m});
    check("R8", {24'd0, cfg_b}, {24'd0, b_m});
    check("R10", {25'd0, cfg_d}, {25'd0, d_m});
  endtask

  task automatic std_read_chk();
    logic [7:0] got, exp;
    string tag;
    exp = exp_std(sidx_m);
    tag = std_tag(sidx_m);
    rd(2'd1, got);
    check(tag, {24'd0, got}, {24'd0, exp});
  endtask

  task automatic ext_read_chk(input string tag);
    logic [7:0] got;
    rd(2'd3, got);
    check(tag, {24'd0, got}, {24'd0, ext_m[eidx_m]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    checks = 0; failures = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    clk_en = 1'b1; tk_time = 80'h0A_0B_0C_0D_0E_0F_10_11_12_13;
    tk_busy = 1'b0; tk_flags = 4'h0; tk_valid = 1'b0;
    a_m = '0; b_m = '0; d_m = '0; sidx_m = '0; eidx_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {24'd0, io_rdata}, 32'd0);
    check("R1", {17'd0, cfg_a, cfg_d, 1'b0}, 32'd0);
    check("R1", {24'd0, cfg_b}, 32'd0);
    rd(2'd0, v); check("R1", {24'd0, v}, 32'd0);
    rd(2'd2, v); check("R1", {24'd0, v}, 32'd0);

    // R2 index ports and hold behaviour
    wr(2'd0, 8'hC5);
    rd(2'd0, v); check("R2", {24'd0, v}, 32'h45);
    repeat (3) @(negedge clk);
    check("R2", {24'd0, io_rdata}, 32'h45);
    wr(2'd2, 8'h7E);
    rd(2'd2, v); check("R2", {24'd0, v}, 32'h7E);

    // fill both banks (R3, R4)
    for (int i = 0; i < 128; i++) begin
      wr(2'd2, 8'(i));
      ext_m[i] = 8'($urandom);
      wr(2'd3, ext_m[i]);
    end
    for (int i = 14; i < 128; i++) begin
      wr(2'd0, 8'(i));
      std_write(8'($urandom));
    end
    wr(2'd2, 8'h00); ext_read_chk("R3");
    wr(2'd2, 8'h7F); ext_read_chk("R3");
    wr(2'd0, 8'h0E); std_read_chk();
    wr(2'd0, 8'h7F); std_read_chk();
    wr(2'd2, 8'h0E); ext_read_chk("R3");

    // R5 time bytes, R6 busy blocking
    wr(2'd0, 8'h00); std_read_chk();
    wr(2'd0, 8'h09); std_read_chk(); std_write(8'h3C);
    tk_busy = 1'b1;
    std_write(8'h55);
    tk_busy = 1'b0;
    wr(2'd0, 8'h04); std_write(8'hA9);

    // R7..R10 control registers
    wr(2'd0, 8'h0A); std_write(8'hFF); std_read_chk();
    tk_busy = 1'b1; std_read_chk(); tk_busy = 1'b0;
    wr(2'd0, 8'h0B); std_write(8'h96); std_read_chk();
    tk_flags = 4'hA;
    wr(2'd0, 8'h0C); std_write(8'hFF); std_read_chk();
    tk_valid = 1'b1;
    wr(2'd0, 8'h0D); std_write(8'h80); std_read_chk();
    std_write(8'h2B); std_read_chk();

    // R11 disabled standard port, R12 extended port still usable
    clk_en = 1'b0;
    wr(2'd0, 8'h20); std_read_chk(); std_write(8'h11);
    wr(2'd0, 8'h0B); std_write(8'h00);
    wr(2'd0, 8'h03); std_write(8'h00);
    rd(2'd0, v); check("R12", {24'd0, v}, 32'h03);
    wr(2'd2, 8'h33); ext_m[8'h33] = 8'hD2; wr(2'd3, 8'hD2); ext_read_chk("R12");
    clk_en = 1'b1;
    wr(2'd0, 8'h20); std_read_chk();
    wr(2'd0, 8'h0B); std_read_chk();

    // random mix
    for (int n = 0; n < 600; n++) begin
      clk_en   = ($urandom % 5) != 0;
      tk_busy  = ($urandom % 3) == 0;
      tk_flags = 4'($urandom);
      tk_valid = 1'($urandom);
      tk_time  = {$urandom, $urandom, 16'($urandom)};
      if (($urandom % 2) == 0) begin
        wr(2'd0, 8'($urandom % 128));
        if (($urandom % 2) == 0) std_write(8'($urandom));
        else std_read_chk();
      end else begin
        wr(2'd2, 8'($urandom));
        if (($urandom % 2) == 0) begin
          ext_m[eidx_m] = 8'($urandom);
          wr(2'd3, ext_m[eidx_m]);
        end
        ext_read_chk(clk_en ? "R3" : "R12");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule